// File: doc/BRIEF.md
# Floppy Disk Controller Register Engine

This block presents a floppy disk controller to a host processor as four byte-wide registers, selected by a two-bit offset: command on write and status on read, track, sector and data. The host loads track and sector, drives the side input, and writes a command code. Every accepted command first runs through a preparation countdown and then an execute countdown. During execution the block moves sector bytes between the data register and an external disk image memory, which it reaches through a synchronous byte port.

The disk geometry is fixed by parameters: 80 cylinders, two sides, nine sectors per track and 512 bytes per sector. Sectors are numbered from 1. Each data byte the host moves during a transfer reloads the execute countdown, so a host that stops accessing the data register lets the command expire. A single-sector read, and any write, ends at the next sector boundary. A multi-sector read carries on into the following sectors. Misuse of the data register and the unsupported track-format command raise a sticky protocol-error output.

Top module: `diskRegEngine`

## Requirements
- R1: After reset the status register (offset 0) reads 0x80, the track (offset 1) and sector (offset 2) registers read 0, protoErr is 0 and hostReady is 1.
- R2: Status bit 7 always reads 1. A command written at clock edge E0 keeps the block in preparation through edges E1 to E4. Busy (status bit 0) is 1 after edges E5 to E9 and 0 after edge E10, provided no data access takes place.
- R3: Status bit 1 (data request) equals busy while a read command (0x80, 0x90) or a write command (0xA0, 0xA2) executes. It stays 0 for seek and restore.
- R4: Restore (0x00) sets the track register to 0 and sets the track-zero flag, status bit 2.
- R5: Seek (0x10, or 0x14 with verify) copies the data register into the track register. It sets track-zero when that value is 0 and clears it otherwise.
- R6: Read and write commands clear track-zero and load the byte address ((track*2 + side)*9 + sector - 1)*512, where side is the sideSel input at the moment the command is written.
- R7: A read of offset 3 while a read command executes holds hostReady low for one cycle and issues memRdEn at the current byte address. In the next cycle it returns memRdata with hostReady high, then advances the address by 1 and reloads the execute countdown.
- R8: A write to offset 3 while a write command executes issues memWrEn with the current byte address and the written byte, then advances the address by 1 and reloads the execute countdown.
- R9: A read with 0x80, or any write, returns to idle right after the access to the last byte of a 512-byte sector. A read with 0x90 continues at the first byte of the next sector.
- R10: When a transfer has no data access for 5 cycles after the last one completed, the command ends: busy is still 1 after 4 edges and is 0 after the 5th.
- R11: Force interrupt (0xD0) returns the block to idle at the next edge, cancelling any countdown, and clears track-zero.
- R12: A write to offset 3 outside an executing write command only loads the data register. It issues no memory write.
- R13: A read of offset 3 outside an executing read command returns the data register at once and sets protoErr, which stays set until reset. Write track (0xF0) also sets protoErr, clears track-zero and leaves the block idle without any memory access.
- R14: The sideSel input selects the side term in the byte address of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access strobe; held until hostReady for reads |
| hostWr | input | 1 | 1 = write access, 0 = read access |
| hostAddr | input | 2 | Register offset: 0 command/status, 1 track, 2 sector, 3 data |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, valid when hostReady is 1 |
| hostReady | output | 1 | Low while a data read waits for memory |
| sideSel | input | 1 | Disk side used by the address calculation |
| memAddr | output | 20 | Disk image byte address |
| memRdEn | output | 1 | Memory read request; data returns the following cycle |
| memWrEn | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, one cycle after memRdEn |
| protoErr | output | 1 | Sticky protocol-error flag |

## Verification
On every cycle, the embedded assertions check the sequencer's phase changes: entry into preparation, the hand-over to execute, expiry on a stall, stopping at a sector end, and force interrupt. They also check that the address steps by one per transfer, that a memory read is answered in the following cycle, that restore clears the track, and that the error flag never drops. The address arithmetic for each side and sector, the byte values returned and written, and the exact length of the busy window can only be shown by the bench's scenarios. So can the difference between single-sector and multi-sector reads and the way a misused data register appears at the ports.

// File: rtl/diskRegPkg.sv
package diskRegPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PREP = 2'd1,
    PH_EXEC = 2'd2
  } phaseT;

  localparam logic [7:0] CMD_RESTORE   = 8'h00;
  localparam logic [7:0] CMD_SEEK      = 8'h10;
  localparam logic [7:0] CMD_SEEK_VFY  = 8'h14;
  localparam logic [7:0] CMD_RD_ONE    = 8'h80;
  localparam logic [7:0] CMD_RD_MANY   = 8'h90;
  localparam logic [7:0] CMD_WR_PROT   = 8'hA0;
  localparam logic [7:0] CMD_WR_PLAIN  = 8'hA2;
  localparam logic [7:0] CMD_FORCE_INT = 8'hD0;
  localparam logic [7:0] CMD_FMT_TRACK = 8'hF0;

  localparam logic [1:0] OFS_CMD  = 2'd0;
  localparam logic [1:0] OFS_TRK  = 2'd1;
  localparam logic [1:0] OFS_SEC  = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic ldTrk;
    logic ldSec;
    logic ldData;
    logic restore;
    logic seek;
    logic xferInit;
    logic clrTrk0;
    logic memRd;
    logic memWr;
    logic advance;
    logic setErr;
    logic rdFromMem;
    logic busy;
    logic dreq;
  } ctrlStrobeT;

endpackage

// File: rtl/diskRegCtrl.sv
module diskRegCtrl
  import diskRegPkg::*;
#(
  parameter int PREP_TICKS = 5,
  parameter int EXEC_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic       secLast,
  output ctrlStrobeT strb,
  output logic       hostReady
);

  localparam int CNT_MAX = (PREP_TICKS > EXEC_TICKS) ? PREP_TICKS : EXEC_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PREP_LOAD = CNT_W'(PREP_TICKS);
  localparam logic [CNT_W-1:0] EXEC_LOAD = CNT_W'(EXEC_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  phaseT            phase;
  logic [CNT_W-1:0] tickCnt;
  logic [7:0]       cmdReg;
  logic             waitRd;

  logic isRdCmd, isWrCmd, isMultiCmd, inExec;
  logic cmdWr, dataRdStart, wrXfer, badRd, advance, stopCode;
  logic newRestore, newSeek, newXfer;

  always_comb begin
    isRdCmd    = (cmdReg == CMD_RD_ONE) || (cmdReg == CMD_RD_MANY);
    isWrCmd    = (cmdReg == CMD_WR_PROT) || (cmdReg == CMD_WR_PLAIN);
    isMultiCmd = (cmdReg == CMD_RD_MANY);
    inExec     = (phase == PH_EXEC);

    cmdWr       = hostSel && hostWr && (hostAddr == OFS_CMD) && !waitRd;
    dataRdStart = hostSel && !hostWr && (hostAddr == OFS_DATA) && inExec && isRdCmd && !waitRd;
    wrXfer      = hostSel && hostWr && (hostAddr == OFS_DATA) && inExec && isWrCmd;
    badRd       = hostSel && !hostWr && (hostAddr == OFS_DATA) && !(inExec && isRdCmd) && !waitRd;
    advance     = waitRd || wrXfer;

    stopCode   = (hostWdata == CMD_FORCE_INT) || (hostWdata == CMD_FMT_TRACK);
    newRestore = (hostWdata == CMD_RESTORE);
    newSeek    = (hostWdata == CMD_SEEK) || (hostWdata == CMD_SEEK_VFY);
    newXfer    = (hostWdata == CMD_RD_ONE) || (hostWdata == CMD_RD_MANY) ||
                 (hostWdata == CMD_WR_PROT) || (hostWdata == CMD_WR_PLAIN);

    strb.ldTrk     = hostSel && hostWr && (hostAddr == OFS_TRK);
    strb.ldSec     = hostSel && hostWr && (hostAddr == OFS_SEC);
    strb.ldData    = hostSel && hostWr && (hostAddr == OFS_DATA) && !(inExec && isWrCmd);
    strb.restore   = cmdWr && newRestore;
    strb.seek      = cmdWr && newSeek;
    strb.xferInit  = cmdWr && newXfer;
    strb.clrTrk0   = cmdWr && (newXfer || stopCode);
    strb.memRd     = dataRdStart;
    strb.memWr     = wrXfer;
    strb.advance   = advance;
    strb.setErr    = badRd || (cmdWr && (hostWdata == CMD_FMT_TRACK));
    strb.rdFromMem = waitRd;
    strb.busy      = inExec;
    strb.dreq      = inExec && (isRdCmd || isWrCmd);

    hostReady = !dataRdStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      cmdReg  <= CMD_RESTORE;
      waitRd  <= 1'b0;
    end else begin
      waitRd <= dataRdStart;
      if (cmdWr) begin
        cmdReg <= hostWdata;
        if (stopCode) begin
          phase   <= PH_IDLE;
          tickCnt <= '0;
        end else begin
          phase   <= PH_PREP;
          tickCnt <= PREP_LOAD;
        end
      end else if (advance) begin
        if (secLast && !isMultiCmd) begin
          phase   <= PH_IDLE;
          tickCnt <= '0;
        end else begin
          tickCnt <= EXEC_LOAD;
        end
      end else if (!dataRdStart) begin
        case (phase)
          PH_PREP: begin
            if (tickCnt == CNT_ONE) begin
              phase   <= PH_EXEC;
              tickCnt <= EXEC_LOAD;
            end else begin
              tickCnt <= tickCnt - CNT_ONE;
            end
          end
          PH_EXEC: begin
            if (tickCnt == CNT_ONE) begin
              phase   <= PH_IDLE;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt - CNT_ONE;
            end
          end
          default: tickCnt <= '0;
        endcase
      end
    end
  end

  // R2
  prep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !stopCode) |=> (phase == PH_PREP && tickCnt == PREP_LOAD));

  // R2
  exec_handover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PREP && tickCnt == CNT_ONE && !cmdWr) |=> (phase == PH_EXEC && tickCnt == EXEC_LOAD));

  // R11
  force_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && hostWdata == CMD_FORCE_INT) |=> (phase == PH_IDLE && tickCnt == '0));

  // R7
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRdStart |=> (waitRd && hostReady && phase == PH_EXEC));

  // R9
  sector_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && secLast && !isMultiCmd && !cmdWr) |=> (phase == PH_IDLE));

  // R10
  stall_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inExec && tickCnt == CNT_ONE && !advance && !dataRdStart && !cmdWr) |=> (phase == PH_IDLE));

endmodule

// File: rtl/diskRegDatapath.sv
module diskRegDatapath
  import diskRegPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int NUM_SIDES    = 2,
  parameter int SECT_PER_TRK = 9,
  parameter int SECT_BYTES   = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic              sideSel,
  input  ctrlStrobeT        strb,
  input  logic [7:0]        memRdata,
  output logic [7:0]        hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              secLast,
  output logic              protoErr
);

  localparam int SECT_SHIFT = $clog2(SECT_BYTES);

  logic [7:0]        trkReg, secReg, dataReg;
  logic [ADDR_W-1:0] byteAddr, xferBase;
  logic [31:0]       secIdx;
  logic              trkZero;
  logic [7:0]        statusByte;

  always_comb begin
    secIdx = ((32'(trkReg) * 32'(NUM_SIDES) + 32'(sideSel)) * 32'(SECT_PER_TRK))
             + 32'(secReg) - 32'd1;
    xferBase   = ADDR_W'(secIdx << SECT_SHIFT);
    secLast    = &byteAddr[SECT_SHIFT-1:0];
    statusByte = {1'b1, 4'b0000, trkZero, strb.dreq, strb.busy};
    memAddr    = byteAddr;
    memWdata   = hostWdata;
    memRdEn    = strb.memRd;
    memWrEn    = strb.memWr;
    if (strb.rdFromMem) begin
      hostRdata = memRdata;
    end else begin
      case (hostAddr)
        OFS_CMD: hostRdata = statusByte;
        OFS_TRK: hostRdata = trkReg;
        OFS_SEC: hostRdata = secReg;
        default: hostRdata = dataReg;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trkReg   <= '0;
      secReg   <= '0;
      dataReg  <= '0;
      byteAddr <= '0;
      trkZero  <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (strb.ldSec)  secReg  <= hostWdata;
      if (strb.ldData) dataReg <= hostWdata;
      if (strb.restore) begin
        trkReg  <= '0;
        trkZero <= 1'b1;
      end else if (strb.seek) begin
        trkReg  <= dataReg;
        trkZero <= (dataReg == 8'd0);
      end else if (strb.ldTrk) begin
        trkReg <= hostWdata;
      end
      if (strb.clrTrk0) trkZero <= 1'b0;
      if (strb.xferInit) begin
        byteAddr <= xferBase;
      end else if (strb.advance) begin
        byteAddr <= byteAddr + ADDR_W'(1);
      end
      if (strb.setErr) protoErr <= 1'b1;
    end
  end

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.xferInit) |=> (byteAddr == $past(byteAddr) + ADDR_W'(1)));

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R4
  restore_trk_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restore |=> (trkReg == 8'd0 && trkZero));

  // R6
  xfer_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferInit |=> !trkZero);

endmodule

// File: rtl/diskRegEngine.sv
module diskRegEngine
  import diskRegPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int NUM_SIDES    = 2,
  parameter int SECT_PER_TRK = 9,
  parameter int SECT_BYTES   = 512,
  parameter int PREP_TICKS   = 5,
  parameter int EXEC_TICKS   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              hostReady,
  input  logic              sideSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              protoErr
);

  ctrlStrobeT strb;
  logic       secLast;

  diskRegCtrl #(
    .PREP_TICKS(PREP_TICKS),
    .EXEC_TICKS(EXEC_TICKS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .secLast  (secLast),
    .strb     (strb),
    .hostReady(hostReady)
  );

  diskRegDatapath #(
    .ADDR_W      (ADDR_W),
    .NUM_SIDES   (NUM_SIDES),
    .SECT_PER_TRK(SECT_PER_TRK),
    .SECT_BYTES  (SECT_BYTES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .sideSel  (sideSel),
    .strb     (strb),
    .memRdata (memRdata),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .secLast  (secLast),
    .protoErr (protoErr)
  );

endmodule

// File: tb/test_diskRegEngine.sv
module test_diskRegEngine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0, sideSel = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [7:0]  hostWdata = 8'd0;
  logic [7:0]  hostRdata, memWdata;
  logic        hostReady, memRdEn, memWrEn, protoErr;
  logic [19:0] memAddr;
  logic [7:0]  memRdata = 8'd0;

  int checks = 0, fails = 0, wrCount = 0, seqErr = 0;
  logic [19:0] lastRdAddr = '0, lastWrAddr = '0;
  logic [7:0]  lastWrData = '0;
  bit          done = 0;

  diskRegEngine i_diskRegEngine (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostReady(hostReady), .sideSel(sideSel),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn), .memWdata(memWdata),
    .memRdata(memRdata), .protoErr(protoErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  function automatic logic [19:0] baseOf(input int trk, input int side, input int sec);
    return 20'(((trk * 2 + side) * 9 + sec - 1) * 512);
  endfunction

  // disk image model: one-cycle read latency, write logging
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdata   <= pat(memAddr);
      lastRdAddr <= memAddr;
    end
    if (memWrEn) begin
      if (wrCount > 0 && memAddr != lastWrAddr + 20'd1) seqErr <= seqErr + 1;
      wrCount    <= wrCount + 1;
      lastWrAddr <= memAddr;
      lastWrData <= memWdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v, output int waits);
    waits = 0;
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1;
    while (!hostReady) begin
      waits++;
      @(posedge clk); #1;
    end
    v = hostRdata;
    @(posedge clk); #1;
    hostSel = 1'b0;
  endtask

  task automatic peek(output logic [7:0] v);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = 2'd0;
    #1;
    v = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic waitBusy();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      peek(s);
      if (s[0]) return;
    end
  endtask

  task automatic testReset();
    logic [7:0] v; int w;
    chk("R1 hostReady", hostReady, 1);
    chk("R1 protoErr", protoErr, 0);
    rdReg(2'd0, v, w); chk("R1 status", v, 8'h80);
    rdReg(2'd1, v, w); chk("R1 track", v, 0);
    rdReg(2'd2, v, w); chk("R1 sector", v, 0);
  endtask

  task automatic testRestore();
    logic [7:0] v; int w;
    wrReg(2'd1, 8'd7);
    wrReg(2'd0, 8'h00);
    rdReg(2'd1, v, w); chk("R4 track cleared", v, 0);
    peek(v); chk("R4 track-zero bit", v[2], 1);
  endtask

  task automatic testSeek();
    logic [7:0] v; int w;
    wrReg(2'd3, 8'h23);
    wrReg(2'd0, 8'h10);
    rdReg(2'd1, v, w); chk("R5 R12 seek loads data reg", v, 8'h23);
    peek(v); chk("R5 track-zero low", v[2], 0);
    chk("R12 no memory write", wrCount, 0);
    wrReg(2'd3, 8'h00);
    wrReg(2'd0, 8'h14);
    rdReg(2'd1, v, w); chk("R5 verify seek to 0", v, 0);
    peek(v); chk("R5 track-zero set", v[2], 1);
  endtask

  task automatic testTiming();
    logic [7:0] v; int bad = 0, badDrq = 0, bad7 = 0;
    wrReg(2'd3, 8'h05);
    wrReg(2'd0, 8'h10);
    for (int j = 0; j <= 10; j++) begin
      peek(v);
      if (v[0] !== ((j >= 5 && j <= 9) ? 1'b1 : 1'b0)) bad++;
      if (v[1] !== 1'b0) badDrq++;
      if (v[7] !== 1'b1) bad7++;
    end
    chk("R2 busy window", bad, 0);
    chk("R2 motor bit", bad7, 0);
    chk("R3 no data request on seek", badDrq, 0);
  endtask

  task automatic testReadSingle();
    logic [7:0] v; int w, dErr = 0, aErr = 0;
    logic [19:0] base;
    base = baseOf(3, 1, 4);
    wrReg(2'd1, 8'd3); wrReg(2'd2, 8'd4);
    sideSel = 1'b1;
    wrReg(2'd0, 8'h80);
    sideSel = 1'b0;
    waitBusy();
    peek(v); chk("R3 data request on read", v[1:0], 2'b11);
    chk("R6 track-zero cleared", v[2], 0);
    rdReg(2'd3, v, w);
    chk("R7 one wait cycle", w, 1);
    chk("R6 R14 side 1 address", lastRdAddr, base);
    chk("R7 first byte", v, pat(base));
    for (int i = 1; i < 512; i++) begin
      rdReg(2'd3, v, w);
      if (lastRdAddr != base + 20'(i)) aErr++;
      if (v != pat(base + 20'(i))) dErr++;
    end
    chk("R7 address sequence", aErr, 0);
    chk("R7 data sequence", dErr, 0);
    peek(v); chk("R9 single read ends at boundary", v[0], 0);
    chk("R13 no error from valid reads", protoErr, 0);
  endtask

  task automatic testReadMulti();
    logic [7:0] v; int w, dErr = 0;
    logic [19:0] base;
    base = baseOf(1, 0, 9);
    wrReg(2'd1, 8'd1); wrReg(2'd2, 8'd9);
    wrReg(2'd0, 8'h90);
    waitBusy();
    for (int i = 0; i < 512; i++) begin
      rdReg(2'd3, v, w);
      if (v != pat(base + 20'(i))) dErr++;
    end
    chk("R6 R14 side 0 address", lastRdAddr, base + 20'd511);
    chk("R7 multi data", dErr, 0);
    peek(v); chk("R9 multi read continues", v[0], 1);
    rdReg(2'd3, v, w);
    chk("R9 next sector address", lastRdAddr, base + 20'd512);
    chk("R9 next sector data", v, pat(base + 20'd512));
    repeat (4) @(posedge clk);
    peek(v); chk("R10 still busy after 4 idle edges", v[0], 1);
    peek(v); chk("R10 ends after 5 idle edges", v[0], 0);
  endtask

  task automatic testWrite();
    logic [7:0] v;
    logic [19:0] base;
    int startCnt;
    base = baseOf(2, 0, 9);
    wrReg(2'd1, 8'd2); wrReg(2'd2, 8'd9);
    wrReg(2'd0, 8'hA2);
    waitBusy();
    peek(v); chk("R3 data request on write", v[1:0], 2'b11);
    startCnt = wrCount;
    wrReg(2'd3, 8'h3C);
    chk("R8 first write address", lastWrAddr, base);
    chk("R8 first write data", lastWrData, 8'h3C);
    for (int i = 1; i < 512; i++) wrReg(2'd3, 8'(i) ^ 8'h3C);
    chk("R8 write count", wrCount - startCnt, 512);
    chk("R8 address sequence", seqErr, 0);
    chk("R8 last write address", lastWrAddr, base + 20'd511);
    chk("R8 last write data", lastWrData, 8'hC3);
    peek(v); chk("R9 write ends at boundary", v[0], 0);
  endtask

  task automatic testForceInt();
    logic [7:0] v;
    wrReg(2'd0, 8'h00);
    peek(v); chk("R4 restore sets track-zero", v[2], 1);
    wrReg(2'd0, 8'hD0);
    peek(v); chk("R11 track-zero cleared", v[2], 0);
    chk("R11 idle", v[0], 0);
    wrReg(2'd0, 8'h80);
    waitBusy();
    wrReg(2'd0, 8'hD0);
    peek(v); chk("R11 aborts execute", v[1:0], 2'b00);
  endtask

  task automatic testBadRead();
    logic [7:0] v; int w;
    chk("R13 error clear before misuse", protoErr, 0);
    wrReg(2'd3, 8'h5A);
    rdReg(2'd3, v, w);
    chk("R13 returns data reg", v, 8'h5A);
    chk("R13 no wait", w, 0);
    chk("R13 error set", protoErr, 1);
  endtask

  task automatic testWriteTrack();
    logic [7:0] v; int cnt;
    cnt = wrCount;
    wrReg(2'd0, 8'h00);
    wrReg(2'd0, 8'hF0);
    peek(v); chk("R13 write track idle", v[0], 0);
    chk("R13 write track clears track-zero", v[2], 0);
    repeat (12) @(posedge clk);
    peek(v); chk("R13 write track stays idle", v[0], 0);
    chk("R13 no memory write", wrCount, cnt);
    chk("R13 error sticky", protoErr, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRestore();
    testSeek();
    testTiming();
    testReadSingle();
    testReadMulti();
    testWrite();
    testForceInt();
    testBadRead();
    testWriteTrack();
    finishRun();
  end

endmodule